// File: doc/BRIEF.md
# Grouped Interrupt Aggregator

This block collects a large number of raw interrupt requests, organised as 19 groups numbered 8 to 26, and folds each group into at most one aggregated interrupt line. Each group holds up to 32 sticky source bits. A raw input that is high for one clock sets its bit. Software clears a bit by writing 1 to it. Each group also has a per-bit enable mask, which is changed only through separate set and clear registers. A read-only result register shows which latched sources are also enabled.

A second layer of set/clear enables works per group. It decides whether the OR of a group's result bits reaches that group's aggregated output line. A read-only activity register shows which groups currently assert their aggregated state. The lines are assigned in a fixed pattern with a gap: groups 8 to 21 drive lines 0 to 13, group 22 drives no line, and groups 23 to 26 drive lines 14 to 17.

Software uses the block through a simple 32-bit register port. Writes take effect on the clock edge, and reads are combinational from the address.

Top module: `irqagg_ctrl`

## Requirements
- R1: After a synchronous reset, every source bit, enable bit and group-enable bit is 0. All registers read 0 and every aggregated line is low.
- R2: A raw source input that is high at a clock edge sets its latched source bit. The bit stays set after the input returns low. The source register of group index k (group number minus 8) is at byte address 20*k.
- R3: Writing a word to a group's source register clears the latched bits that are 1 in the word and leaves the other bits alone. If a raw set and a clearing write hit the same bit at the same edge, the bit ends up set.
- R4: Writing to the enable-set register at 20*k+4 sets the enable bits that are 1 in the word. Writing to the enable-clear register at 20*k+12 clears them. Zero bits leave the mask unchanged, and both addresses read back the current mask.
- R5: The register at 20*k+8 reads the source bits AND the enable mask, and writes to it change nothing.
- R6: Address 0x200 sets and address 0x204 clears group-enable bits, where bit n belongs to group number n. Only bits 8 to 26 exist. Other bits read 0 and writing them has no effect. Both addresses read back the group-enable bits.
- R7: The read-only register at 0x208 sets bit n, for n from 8 to 26, when group n has its group enable set and at least one result bit set. Writes to it change nothing.
- R8: Aggregated line j follows the activity of group j+8 for j from 0 to 13, and of group j+9 for j from 14 to 17. Group 22 drives no line.
- R9: The activity register and the lines are registered. They show a state change one clock edge after the edge that made it.
- R10: The slot at 20*k+16, the addresses from 0x17C to 0x1FF, and addresses above 0x208 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, takes effect at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| src_in | input | 608 | Raw sources; group index k uses bits 32*k+31 down to 32*k |
| agg_irq | output | 18 | Aggregated interrupt lines |

## Verification
Every group in turn is given a different raw source pattern and an enable pattern that overlaps it only partly. This shows whether the result masks bit by bit, and whether a write to one group leaks into a neighbouring group. Group enables build up across the sweep and then fall away. Each step compares the whole register file and all 18 lines against a model, so a wrong line assignment or a missing gap at group 22 shows up as a mismatch on a particular line. Extra patterns cover a clear and a raw set on the same bit in the same cycle, a clear of only part of a group's bits, and writes of all ones to read-only, reserved and out-of-range addresses. A check taken just after the enabling edge confirms the one-cycle delay.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

    localparam int GRP_CNT    = 19;
    localparam int GRP_FIRST  = 8;
    localparam int SRC_W      = 32;
    localparam int REG_W      = 32;
    localparam int ADDR_W     = 12;
    localparam int OUT_CNT    = 18;
    localparam int GRP_STRIDE = 20;

    localparam logic [ADDR_W-1:0] BLK_SET_ADDR = 12'h200;
    localparam logic [ADDR_W-1:0] BLK_CLR_ADDR = 12'h204;
    localparam logic [ADDR_W-1:0] BLK_ACT_ADDR = 12'h208;

    typedef enum logic [2:0] {
        SLOT_SRC    = 3'd0,
        SLOT_ENSET  = 3'd1,
        SLOT_RESULT = 3'd2,
        SLOT_ENCLR  = 3'd3,
        SLOT_RSVD   = 3'd4
    } slot_e;

    typedef struct packed {
        logic wr_src;
        logic wr_enset;
        logic wr_enclr;
    } grp_wr_t;

    // Output line for a group number; -1 when the group has no line.
    function automatic int out_line(input int grp_num);
        if (grp_num < GRP_FIRST || grp_num > GRP_FIRST + GRP_CNT - 1) return -1;
        if (grp_num <= 21) return grp_num - GRP_FIRST;
        if (grp_num == 22) return -1;
        return grp_num - GRP_FIRST - 1;
    endfunction

endpackage

// File: rtl/irqagg_group.sv
module irqagg_group
    import irqagg_pkg::*;
#(
    parameter int W = SRC_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] src_raw,
    input  grp_wr_t      wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] src_q,
    output logic [W-1:0] en_q,
    output logic [W-1:0] result,
    output logic         any_hit
);

    logic [W-1:0] clr_mask;
    logic [W-1:0] set_mask;
    logic [W-1:0] off_mask;

    assign clr_mask = wr.wr_src   ? wdata : '0;
    assign set_mask = wr.wr_enset ? wdata : '0;
    assign off_mask = wr.wr_enclr ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q <= '0;
            en_q  <= '0;
        end else begin
            src_q <= (src_q & ~clr_mask) | src_raw;
            en_q  <= (en_q | set_mask) & ~off_mask;
        end
    end

    assign result  = src_q & en_q;
    assign any_hit = |result;

    assert_sticky_set_R2: assert property (@(posedge clk) disable iff (rst)
        (src_raw != '0) |=> ((src_q & $past(src_raw)) == $past(src_raw)));

    assert_w1c_R3: assert property (@(posedge clk) disable iff (rst)
        wr.wr_src |=> ((src_q & $past(wdata) & ~$past(src_raw)) == '0));

    assert_enset_R4: assert property (@(posedge clk) disable iff (rst)
        wr.wr_enset |=> ((en_q & $past(wdata)) == $past(wdata)));

    assert_enclr_R4: assert property (@(posedge clk) disable iff (rst)
        wr.wr_enclr |=> ((en_q & $past(wdata)) == '0));

endmodule

// File: rtl/irqagg_blk.sv
module irqagg_blk
    import irqagg_pkg::*;
#(
    parameter int NG    = GRP_CNT,
    parameter int FIRST = GRP_FIRST,
    parameter int NO    = OUT_CNT
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NG-1:0] any_grp,
    input  logic          wr_set,
    input  logic          wr_clr,
    input  logic [NG-1:0] wbits,
    output logic [NG-1:0] blk_en,
    output logic [NG-1:0] active,
    output logic [NO-1:0] agg_irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            blk_en <= '0;
            active <= '0;
        end else begin
            blk_en <= (blk_en | (wr_set ? wbits : '0)) & ~(wr_clr ? wbits : '0);
            active <= blk_en & any_grp;
        end
    end

    for (genvar i = 0; i < NG; i++) begin : g_map
        localparam int LINE = out_line(i + FIRST);
        if (LINE >= 0) begin : g_line
            assign agg_irq[LINE] = active[i];
        end
    end

    assert_gate_R7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((active & ~$past(blk_en)) == '0));

    assert_blkset_R6: assert property (@(posedge clk) disable iff (rst)
        wr_set |=> ((blk_en & $past(wbits)) == $past(wbits)));

    assert_blkclr_R6: assert property (@(posedge clk) disable iff (rst)
        wr_clr |=> ((blk_en & $past(wbits)) == '0));

endmodule

// File: rtl/irqagg_ctrl.sv
module irqagg_ctrl
    import irqagg_pkg::*;
#(
    parameter int NG    = GRP_CNT,
    parameter int W     = SRC_W,
    parameter int AW    = ADDR_W,
    parameter int NO    = OUT_CNT,
    parameter int FIRST = GRP_FIRST
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_wr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    input  logic [NG*W-1:0] src_in,
    output logic [NO-1:0]   agg_irq
);

    localparam int PAD_HI = REG_W - NG - FIRST;

    logic [W-1:0] src_q  [NG];
    logic [W-1:0] en_q   [NG];
    logic [W-1:0] result [NG];
    logic [NG-1:0] grp_any;
    logic [NG-1:0] grp_hit;
    slot_e         grp_slot [NG];
    logic [NG-1:0] blk_en;
    logic [NG-1:0] blk_act;
    logic          blk_set_wr;
    logic          blk_clr_wr;

    for (genvar i = 0; i < NG; i++) begin : g_grp
        localparam logic [AW-1:0] BASE = AW'(i * GRP_STRIDE);
        logic [AW-1:0] rel;
        grp_wr_t       wr;

        assign rel         = bus_addr - BASE;
        assign grp_hit[i]  = (bus_addr >= BASE) && (rel < AW'(GRP_STRIDE));
        assign grp_slot[i] = slot_e'(rel[4:2]);
        assign wr.wr_src   = bus_wr && grp_hit[i] && (grp_slot[i] == SLOT_SRC);
        assign wr.wr_enset = bus_wr && grp_hit[i] && (grp_slot[i] == SLOT_ENSET);
        assign wr.wr_enclr = bus_wr && grp_hit[i] && (grp_slot[i] == SLOT_ENCLR);

        irqagg_group #(.W(W)) u_grp (
            .clk     (clk),
            .rst     (rst),
            .src_raw (src_in[i*W +: W]),
            .wr      (wr),
            .wdata   (bus_wdata[W-1:0]),
            .src_q   (src_q[i]),
            .en_q    (en_q[i]),
            .result  (result[i]),
            .any_hit (grp_any[i])
        );
    end

    assign blk_set_wr = bus_wr && (bus_addr == BLK_SET_ADDR);
    assign blk_clr_wr = bus_wr && (bus_addr == BLK_CLR_ADDR);

    irqagg_blk #(.NG(NG), .FIRST(FIRST), .NO(NO)) u_blk (
        .clk     (clk),
        .rst     (rst),
        .any_grp (grp_any),
        .wr_set  (blk_set_wr),
        .wr_clr  (blk_clr_wr),
        .wbits   (bus_wdata[FIRST +: NG]),
        .blk_en  (blk_en),
        .active  (blk_act),
        .agg_irq (agg_irq)
    );

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NG; i++) begin
            if (grp_hit[i]) begin
                case (grp_slot[i])
                    SLOT_SRC:               bus_rdata = REG_W'(src_q[i]);
                    SLOT_ENSET, SLOT_ENCLR: bus_rdata = REG_W'(en_q[i]);
                    SLOT_RESULT:            bus_rdata = REG_W'(result[i]);
                    default:                bus_rdata = '0;
                endcase
            end
        end
        if (bus_addr == BLK_SET_ADDR || bus_addr == BLK_CLR_ADDR)
            bus_rdata = {{PAD_HI{1'b0}}, blk_en, {FIRST{1'b0}}};
        else if (bus_addr == BLK_ACT_ADDR)
            bus_rdata = {{PAD_HI{1'b0}}, blk_act, {FIRST{1'b0}}};
    end

    assert_line_count_R8: assert property (@(posedge clk) disable iff (rst)
        $countones(agg_irq) <= $countones(blk_act));

    assert_onehot_hit_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grp_hit));

endmodule

// File: tb/irqagg_ctrl_test.sv
`timescale 1ns/1ps
module irqagg_ctrl_test;

    localparam int NG = 19;
    localparam int W  = 32;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [11:0]     bus_addr = '0;
    logic            bus_wr = 1'b0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NG*W-1:0] src_in = '0;
    logic [17:0]     agg_irq;

    irqagg_ctrl uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_in(src_in),
        .agg_irq(agg_irq)
    );

    always #2 clk = ~clk;

    int nvec = 0;
    int nerr = 0;
    bit done = 1'b0;

    logic [31:0] src_m [NG];
    logic [31:0] en_m  [NG];
    logic [NG-1:0] blk_m;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [NG-1:0] exp_act();
        logic [NG-1:0] a;
        for (int g = 0; g < NG; g++) a[g] = blk_m[g] && ((src_m[g] & en_m[g]) != 0);
        return a;
    endfunction

    function automatic logic [17:0] exp_lines();
        logic [17:0] l = '0;
        logic [NG-1:0] a = exp_act();
        for (int g = 0; g < NG; g++) begin
            int num = g + 8;
            if (num <= 21) l[num-8] = a[g];
            else if (num >= 23) l[num-9] = a[g];
        end
        return l;
    endfunction

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
        if (a == 12'h200) blk_m = blk_m | d[26:8];
        else if (a == 12'h204) blk_m = blk_m & ~d[26:8];
        else if (a < 12'h17C) begin
            int g = a / 20;
            int s = (a % 20) / 4;
            if (s == 0) src_m[g] = src_m[g] & ~d;
            else if (s == 1) en_m[g] = en_m[g] | d;
            else if (s == 3) en_m[g] = en_m[g] & ~d;
        end
    endtask

    task automatic pulse(input int g, input logic [31:0] p);
        @(negedge clk);
        src_in[g*W +: W] = p;
        @(negedge clk);
        src_in = '0;
        src_m[g] = src_m[g] | p;
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    task automatic check_all();
        @(negedge clk);
        @(negedge clk);
        for (int g = 0; g < NG; g++) begin
            rd_chk("R2 source", 12'(g*20), src_m[g]);
            rd_chk("R4 enset", 12'(g*20+4), en_m[g]);
            rd_chk("R5 result", 12'(g*20+8), src_m[g] & en_m[g]);
            rd_chk("R4 enclr", 12'(g*20+12), en_m[g]);
            rd_chk("R10 slot", 12'(g*20+16), 32'h0);
        end
        rd_chk("R6 blkset", 12'h200, {5'b0, blk_m, 8'b0});
        rd_chk("R6 blkclr", 12'h204, {5'b0, blk_m, 8'b0});
        rd_chk("R7 active", 12'h208, {5'b0, exp_act(), 8'b0});
        rd_chk("R10 gap", 12'h17C, 32'h0);
        rd_chk("R10 gap", 12'h1FC, 32'h0);
        rd_chk("R10 high", 12'h20C, 32'h0);
        chk("R8 lines", {14'b0, agg_irq}, {14'b0, exp_lines()});
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            nerr++; nvec++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    initial begin
        for (int g = 0; g < NG; g++) begin src_m[g] = '0; en_m[g] = '0; end
        blk_m = '0;
        repeat (4) @(negedge clk);
        // R1: reset values, including with raw inputs forced during reset
        src_in = '1;
        @(negedge clk);
        src_in = '0;
        @(negedge clk);
        rst = 1'b0;
        check_all();

        // R2 R4 R5 R8 R9: sweep every group with distinct patterns
        for (int g = 0; g < NG; g++) begin
            logic [31:0] p = (32'h1 << g) | (32'h0001_0001 << (g % 16));
            logic [31:0] e = (32'h1 << g) | 32'h00F0_0F00;
            pulse(g, p);
            wr(12'(g*20+4), e);
            wr(12'h200, 32'h1 << (g + 8));
            // R9: line still old right after the enabling edge
            chk("R9 delay", {14'b0, agg_irq},
                {14'b0, exp_lines() & ~(((g + 8) <= 21) ? 18'(1 << g) :
                                        ((g + 8) >= 23) ? 18'(1 << (g - 1)) : 18'h0)});
            check_all();
        end

        // R4: partial enable clear
        for (int g = 0; g < NG; g += 3) begin
            wr(12'(g*20+12), 32'h00F0_0000);
        end
        check_all();

        // R3: collision of raw set and clear on the same bit
        @(negedge clk);
        src_in[3*W +: W] = 32'h0000_0020;
        bus_addr = 12'(3*20); bus_wr = 1'b1; bus_wdata = 32'h0000_0020;
        @(negedge clk);
        src_in = '0; bus_wr = 1'b0; bus_wdata = '0;
        src_m[3] = src_m[3] | 32'h0000_0020;
        rd_chk("R3 collision", 12'(3*20), src_m[3]);

        // R3: partial clear leaves other bits
        for (int g = 0; g < NG; g++) wr(12'(g*20), 32'h0000_FFFF);
        check_all();

        // R5 R7 R10: writes to read-only and reserved addresses
        wr(12'(5*20+8), 32'hFFFF_FFFF);
        wr(12'(7*20+16), 32'hFFFF_FFFF);
        wr(12'h17C, 32'hFFFF_FFFF);
        wr(12'h1F0, 32'hFFFF_FFFF);
        wr(12'h208, 32'hFFFF_FFFF);
        wr(12'h300, 32'hFFFF_FFFF);
        check_all();

        // R6: only bits 8..26 exist
        wr(12'h204, 32'hFFFF_FFFF);
        check_all();
        wr(12'h200, 32'hFFFF_FFFF);
        check_all();

        // R3: clear all sources, lines drop
        for (int g = 0; g < NG; g++) wr(12'(g*20), 32'hFFFF_FFFF);
        check_all();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

endmodule